// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is the host side of a serial NOR flash link. A client hands it one request at a time over a ready/valid channel: read a run of bytes (normal or fast read), read the identification bytes, program a single byte, or erase a 4 KB sector or a 64 KB block. The block turns each request into correctly framed serial transactions. It drives chip-select, the serial clock and the outgoing data line, and it samples the incoming data line.

Every modifying request becomes a chain of frames. First comes a frame that holds only the write-enable command. Next comes the program or erase frame. After that, status-read frames repeat until the flash reports it is no longer busy. Only then does the request complete. Read data returns one byte per response beat. The final beat is flagged. A stalled response channel pauses the serial clock between bytes, so no data is lost.

The serial clock runs in mode 0: it idles low, the flash samples on the rising edge, and outgoing data changes on the falling edge. Each half period lasts `clk_div_i + 1` system clocks.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `spi_cs_no` is 1, `spi_sclk_o` is 0, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: The serial clock idles low. Each high phase lasts `clk_div_i + 1` system clocks. `spi_mosi_o` does not change while `spi_sclk_o` is high or at its rising edge.
- R3: Every frame carries a whole number of 8-bit bytes, each sent most significant bit first. An address goes out as three bytes, high byte first.
- R4: The request code `req_op_i` = 0 (normal read) sends 03h and the address, then clocks in N = `req_len_i` + 1 bytes. It returns them in order, with `rsp_last_o` set on the Nth byte only.
- R5: The request code 1 (fast read) sends 0Bh, the address and one dummy byte of 00h, then returns N bytes in the same way as R4.
- R6: The request code 5 (ID read) sends 9Fh with no address, then returns N bytes.
- R7: The request codes 2 (program), 3 (4 KB erase) and 4 (64 KB erase) first send a frame that carries only 06h.
- R8: The program frame is 02h, the address and `req_wdata_i`. The erase frames are 20h (code 3) or D8h (code 4) followed by the address, with nothing after it.
- R9: After a program or erase frame, the block sends two-byte status frames (05h, then one byte read). It repeats them while bit 0 of the byte read is 1. It completes with one response that carries the final status byte with `rsp_last_o` = 1.
- R10: Between any two frames, `spi_cs_no` stays high for at least GAP_CYC (default 2) system clocks.
- R11: `spi_sclk_o` stays low whenever `spi_cs_no` is high. Chip-select rises only after the final falling clock edge of a frame's last byte.
- R12: `req_ready_o` is high only while the block is idle with chip-select high. A pending response keeps `rsp_valid_o`, `rsp_data_o` and `rsp_last_o` unchanged until `rsp_ready_i` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_div_i | input | DIV_W | Serial clock half period minus one, in system clocks |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_op_i | input | 3 | Request code: 0 read, 1 fast read, 2 program, 3 erase 4 KB, 4 erase 64 KB, 5 ID read |
| req_addr_i | input | 24 | Byte address |
| req_len_i | input | LEN_W | Read byte count minus one |
| req_wdata_i | input | 8 | Byte to program |
| rsp_valid_o | output | 1 | Response beat valid |
| rsp_ready_i | input | 1 | Response beat taken |
| rsp_data_o | output | 8 | Read byte or final status byte |
| rsp_last_o | output | 1 | Last beat of the request |
| spi_cs_no | output | 1 | Chip-select, active low |
| spi_sclk_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
The bench runs each of the six request kinds against a behavioural flash slave. The data the slave returns depends on both address and position. A wrong address byte, a missing or extra dummy byte, or a shifted read therefore each produce a different data mismatch. Modifying requests are run with zero, one, two and three busy status replies. Each busy reply has a second status bit set, which shows whether the loop length follows bit 0 alone. The divider is varied between 0, 1 and 3, and the response channel is throttled with an irregular pattern. Together these separate half-period errors and beats lost or altered under backpressure from the framing errors.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] OPC_READ   = 8'h03;
  localparam logic [7:0] OPC_FREAD  = 8'h0B;
  localparam logic [7:0] OPC_PROG   = 8'h02;
  localparam logic [7:0] OPC_ERS4K  = 8'h20;
  localparam logic [7:0] OPC_ERS64K = 8'hD8;
  localparam logic [7:0] OPC_RDID   = 8'h9F;
  localparam logic [7:0] OPC_RDSR   = 8'h05;
  localparam logic [7:0] OPC_WREN   = 8'h06;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_FREAD  = 3'd1,
    OP_PROG   = 3'd2,
    OP_ERS4K  = 3'd3,
    OP_ERS64K = 3'd4,
    OP_RDID   = 3'd5
  } req_op_e;

  typedef enum logic [1:0] {FR_WREN, FR_CMD, FR_STAT} frame_e;

  typedef enum logic [2:0] {ST_IDLE, ST_SEL, ST_BYTE, ST_RSP, ST_GAP} seq_state_e;

  function automatic logic [7:0] op_code(req_op_e op);
    case (op)
      OP_READ:   return OPC_READ;
      OP_FREAD:  return OPC_FREAD;
      OP_PROG:   return OPC_PROG;
      OP_ERS4K:  return OPC_ERS4K;
      OP_ERS64K: return OPC_ERS64K;
      default:   return OPC_RDID;
    endcase
  endfunction

  // bytes sent before any read byte, opcode included
  function automatic logic [2:0] cmd_hdr(req_op_e op);
    case (op)
      OP_READ, OP_ERS4K, OP_ERS64K: return 3'd4;
      OP_FREAD, OP_PROG:            return 3'd5;
      default:                      return 3'd1;
    endcase
  endfunction

  function automatic logic op_modifies(req_op_e op);
    return (op == OP_PROG) || (op == OP_ERS4K) || (op == OP_ERS64K);
  endfunction

endpackage

// File: rtl/flash_sclk_div.sv
module flash_sclk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || cnt_q == div_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == div_i);
endmodule

// File: rtl/flash_byte_shift.sv
module flash_byte_shift
  import flash_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rx_o,
  output logic              sclk_o,
  output logic              mosi_o
);
  localparam int unsigned BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic              busy_q, done_q, sclk_q;
  logic [BYTE_W-1:0] tx_q, rx_q;
  logic [BIT_W-1:0]  bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        sclk_q <= 1'b0;
        tx_q   <= tx_i;
        bit_q  <= '0;
      end else if (busy_q && tick_i) begin
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[BYTE_W-2:0], miso_i};
        end else begin
          // falling edge: advance data or close the byte
          sclk_q <= 1'b0;
          if (bit_q == LAST_BIT) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[BYTE_W-1];
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned GAP_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] clk_div_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [2:0]       req_op_i,
  input  logic [23:0]      req_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [7:0]       req_wdata_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [7:0]       rsp_data_o,
  output logic             rsp_last_o,
  output logic             spi_cs_no,
  output logic             spi_sclk_o,
  output logic             spi_mosi_o,
  input  logic             spi_miso_i
);
  localparam int unsigned GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [GAP_W-1:0] GAP_END = GAP_W'(GAP_CYC - 1);

  seq_state_e       state_q;
  frame_e           frame_q;
  req_op_e          op_q;
  logic [23:0]      addr_q;
  logic [7:0]       wdata_q;
  logic [LEN_W-1:0] left_q;
  logic [2:0]       idx_q;
  logic             fin_q, cs_n_q;
  logic [GAP_W-1:0] gap_q;
  logic             rsp_valid_q, rsp_last_q;
  logic [7:0]       rsp_data_q;

  logic       tick, xfer_busy, xfer_done, xfer_start;
  logic [7:0] xfer_rx, tx_byte;
  logic [2:0] hdr_n;
  logic       frame_rx;

  flash_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (xfer_busy),
    .div_i  (clk_div_i),
    .tick_o (tick)
  );

  flash_byte_shift u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (xfer_start),
    .tx_i    (tx_byte),
    .tick_i  (tick),
    .miso_i  (spi_miso_i),
    .busy_o  (xfer_busy),
    .done_o  (xfer_done),
    .rx_o    (xfer_rx),
    .sclk_o  (spi_sclk_o),
    .mosi_o  (spi_mosi_o)
  );

  assign xfer_start = (state_q == ST_SEL);

  always_comb begin
    case (frame_q)
      FR_CMD: begin
        hdr_n    = cmd_hdr(op_q);
        frame_rx = !op_modifies(op_q);
      end
      FR_STAT: begin
        hdr_n    = 3'd1;
        frame_rx = 1'b1;
      end
      default: begin
        hdr_n    = 3'd1;
        frame_rx = 1'b0;
      end
    endcase
  end

  always_comb begin
    tx_byte = 8'h00;
    if (idx_q < hdr_n) begin
      case (frame_q)
        FR_WREN: tx_byte = OPC_WREN;
        FR_STAT: tx_byte = OPC_RDSR;
        default: begin
          case (idx_q)
            3'd0:    tx_byte = op_code(op_q);
            3'd1:    tx_byte = addr_q[23:16];
            3'd2:    tx_byte = addr_q[15:8];
            3'd3:    tx_byte = addr_q[7:0];
            default: tx_byte = (op_q == OP_PROG) ? wdata_q : 8'h00;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      frame_q     <= FR_CMD;
      op_q        <= OP_READ;
      addr_q      <= '0;
      wdata_q     <= '0;
      left_q      <= '0;
      idx_q       <= '0;
      fin_q       <= 1'b0;
      cs_n_q      <= 1'b1;
      gap_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_last_q  <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            op_q    <= req_op_e'(req_op_i);
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
            left_q  <= req_len_i;
            frame_q <= op_modifies(req_op_e'(req_op_i)) ? FR_WREN : FR_CMD;
            idx_q   <= '0;
            cs_n_q  <= 1'b0;
            state_q <= ST_SEL;
          end
        end
        ST_SEL: state_q <= ST_BYTE;
        ST_BYTE: begin
          if (xfer_done) begin
            if (idx_q < hdr_n - 3'd1) begin
              idx_q   <= idx_q + 3'd1;
              state_q <= ST_SEL;
            end else if (idx_q == hdr_n - 3'd1) begin
              if (frame_rx) begin
                idx_q   <= idx_q + 3'd1;
                state_q <= ST_SEL;
              end else begin
                // header-only frame done: chain the next frame
                cs_n_q  <= 1'b1;
                fin_q   <= 1'b0;
                frame_q <= (frame_q == FR_WREN) ? FR_CMD : FR_STAT;
                state_q <= ST_GAP;
              end
            end else if (frame_q == FR_STAT) begin
              cs_n_q <= 1'b1;
              if (xfer_rx[0]) begin
                fin_q   <= 1'b0;
                state_q <= ST_GAP;
              end else begin
                rsp_valid_q <= 1'b1;
                rsp_data_q  <= xfer_rx;
                rsp_last_q  <= 1'b1;
                state_q     <= ST_RSP;
              end
            end else begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= xfer_rx;
              rsp_last_q  <= (left_q == '0);
              if (left_q == '0) cs_n_q <= 1'b1;
              state_q <= ST_RSP;
            end
          end
        end
        ST_RSP: begin
          if (rsp_ready_i) begin
            rsp_valid_q <= 1'b0;
            if (rsp_last_q) begin
              fin_q   <= 1'b1;
              state_q <= ST_GAP;
            end else begin
              left_q  <= left_q - 1'b1;
              state_q <= ST_SEL;
            end
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_END) begin
            gap_q <= '0;
            if (fin_q) begin
              state_q <= ST_IDLE;
            end else begin
              cs_n_q  <= 1'b0;
              idx_q   <= '0;
              state_q <= ST_SEL;
            end
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign rsp_last_o  = rsp_last_q;
  assign spi_cs_no   = cs_n_q;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int unsigned GAP_CYC = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ready_o,
  input logic       rsp_valid_o,
  input logic       rsp_ready_i,
  input logic [7:0] rsp_data_o,
  input logic       rsp_last_o,
  input logic       spi_cs_no,
  input logic       spi_sclk_o,
  input logic       spi_mosi_o
);
  localparam int unsigned HI_W = $clog2(GAP_CYC + 1);

  logic [HI_W-1:0] hi_cnt;
  logic [2:0]      rise_cnt;
  logic            sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt   <= HI_W'(GAP_CYC);
      rise_cnt <= '0;
      sclk_d   <= 1'b0;
    end else begin
      sclk_d <= spi_sclk_o;
      if (spi_cs_no) begin
        hi_cnt   <= (hi_cnt == HI_W'(GAP_CYC)) ? hi_cnt : hi_cnt + 1'b1;
        rise_cnt <= '0;
      end else begin
        hi_cnt <= '0;
        if (spi_sclk_o && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
      end
    end
  end

  a_r2_mosi_steady_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_sclk_o && $past(spi_sclk_o)) |-> $stable(spi_mosi_o));

  a_r2_mosi_steady_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_sclk_o) |-> $stable(spi_mosi_o));

  a_r3_whole_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_cs_no) |-> (rise_cnt == 3'd0));

  a_r10_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_cs_no) |-> (hi_cnt >= HI_W'(GAP_CYC)));

  a_r11_sclk_low_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sclk_o);

  a_r11_cs_rise_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_cs_no) |-> !$past(spi_sclk_o));

  a_r12_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (spi_cs_no && !rsp_valid_o));

  a_r12_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_data_o) && $stable(rsp_last_o)));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_data_o  (rsp_data_o),
  .rsp_last_o  (rsp_last_o),
  .spi_cs_no   (spi_cs_no),
  .spi_sclk_o  (spi_sclk_o),
  .spi_mosi_o  (spi_mosi_o)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] clk_div = 8'd1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_op = 3'd0;
  logic [23:0] req_addr = '0;
  logic [7:0] req_len = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid, rsp_ready, rsp_last;
  logic [7:0] rsp_data;
  logic       cs_n, sclk, mosi, miso;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int plan_busy = 0;
  int busy_left = 0;
  bit finished = 1'b0;

  logic [63:0] exp_frame[$];
  string       exp_frame_tag[$];
  logic [8:0]  exp_rsp[$];
  string       exp_rsp_tag[$];

  always #5 clk = ~clk;

  flash_cmd_seq u_flash_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .clk_div_i(clk_div),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data),
    .rsp_last_o(rsp_last), .spi_cs_no(cs_n), .spi_sclk_o(sclk),
    .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h3C;
  endfunction

  function automatic logic [7:0] id_byte(input int k);
    return 8'hC2 + 8'(k * 17);
  endfunction

  // flash slave model, sampled between system clock edges
  logic [7:0] fb[6];
  logic [7:0] sh_in, out_b;
  int bit_in = 0, nb = 0, hi_run = 0, cs_hi = 100;
  logic cs_p = 1'b1, sclk_p = 1'b0;

  function automatic logic [7:0] slave_byte(input int n);
    logic [23:0] a;
    a = {fb[1], fb[2], fb[3]};
    case (fb[0])
      8'h03: return (n >= 4) ? mem_byte(a + 24'(n - 4)) : 8'h00;
      8'h0B: return (n >= 5) ? mem_byte(a + 24'(n - 5)) : 8'h00;
      8'h9F: return (n >= 1) ? id_byte(n - 1) : 8'h00;
      8'h05: return (busy_left > 0) ? 8'h03 : 8'h02;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    miso = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (cs_p && !cs_n) begin
          chk(cs_hi >= 2, "R10", "cs high gap", 64'(cs_hi), 64'd2);
          bit_in = 0; nb = 0; out_b = 8'h00; miso = 1'b0;
          foreach (fb[i]) fb[i] = 8'h00;
        end
        cs_hi = cs_n ? cs_hi + 1 : 0;
        if (cs_n && sclk) chk(1'b0, "R11", "sclk high while deselected", 64'(sclk), 64'd0);
        if (!cs_n && req_ready) chk(1'b0, "R12", "ready during frame", 64'(req_ready), 64'd0);
        if (sclk) hi_run++;
        if (!cs_n) begin
          if (sclk && !sclk_p) begin
            sh_in = {sh_in[6:0], mosi};
            bit_in++;
            if (bit_in == 8) begin
              if (nb < 6) fb[nb] = sh_in;
              nb++;
              bit_in = 0;
              out_b = slave_byte(nb);
            end
          end
          if (!sclk && sclk_p) miso = out_b[7 - bit_in];
        end
        if (!sclk && sclk_p) begin
          chk(hi_run == int'(clk_div) + 1, "R2", "sclk high phase", 64'(hi_run), 64'(clk_div) + 1);
          hi_run = 0;
        end
        if (!cs_p && cs_n) begin
          chk(bit_in == 0, "R3", "partial byte at cs release", 64'(bit_in), 64'd0);
          if (exp_frame.size() == 0) begin
            chk(1'b0, "R7", "unexpected frame", {8'h0, fb[0], 16'(nb), fb[1], fb[2], fb[3], fb[4]}, 64'd0);
          end else begin
            logic [63:0] e;
            string t;
            e = exp_frame.pop_front();
            t = exp_frame_tag.pop_front();
            // opcode, byte count, address bytes high first (R3), fifth byte
            chk({8'h0, fb[0], 16'(nb), fb[1], fb[2], fb[3], fb[4]} == e, t, "frame",
                {8'h0, fb[0], 16'(nb), fb[1], fb[2], fb[3], fb[4]}, e);
          end
          if (fb[0] == 8'h02 || fb[0] == 8'h20 || fb[0] == 8'hD8) busy_left = plan_busy;
          if (fb[0] == 8'h05 && busy_left > 0) busy_left--;
        end
      end
      cs_p = cs_n;
      sclk_p = sclk;
    end
  end

  // response monitor with throttled ready
  initial begin
    bit held = 1'b0;
    logic [8:0] held_v;
    rsp_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (held) begin
        chk(rsp_valid && {rsp_last, rsp_data} == held_v, "R12", "held response",
            {55'h0, rsp_valid, rsp_last, rsp_data}, {55'h0, 1'b1, held_v});
      end
      rsp_ready = ((cyc % 5) != 2) && ((cyc % 37) > 8);
      held = rsp_valid && !rsp_ready;
      held_v = {rsp_last, rsp_data};
      if (rsp_valid && rsp_ready) begin
        if (exp_rsp.size() == 0) begin
          chk(1'b0, "R4", "unexpected response", {55'h0, rsp_last, rsp_data}, 64'd0);
        end else begin
          logic [8:0] e;
          string t;
          e = exp_rsp.pop_front();
          t = exp_rsp_tag.pop_front();
          chk({rsp_last, rsp_data} == e, t, "response", {55'h0, rsp_last, rsp_data}, {55'h0, e});
        end
      end
    end
  end

  task automatic push_frame(input string t, input logic [7:0] op, input int n,
                            input logic [23:0] a, input logic [7:0] b4);
    exp_frame.push_back({8'h0, op, 16'(n), a, b4});
    exp_frame_tag.push_back(t);
  endtask

  task automatic run_req(input logic [2:0] op, input logic [23:0] a, input int n,
                         input logic [7:0] wd, input int busy);
    plan_busy = busy;
    case (op)
      3'd0, 3'd1, 3'd5: begin
        string t;
        t = (op == 3'd0) ? "R4" : (op == 3'd1) ? "R5" : "R6";
        if (op == 3'd0) push_frame(t, 8'h03, 4 + n, a, 8'h00);
        else if (op == 3'd1) push_frame(t, 8'h0B, 5 + n, a, 8'h00);
        else push_frame(t, 8'h9F, 1 + n, 24'h0, 8'h00);
        for (int k = 0; k < n; k++) begin
          exp_rsp.push_back({k == n - 1, (op == 3'd5) ? id_byte(k) : mem_byte(a + 24'(k))});
          exp_rsp_tag.push_back(t);
        end
      end
      default: begin
        push_frame("R7", 8'h06, 1, 24'h0, 8'h00);
        if (op == 3'd2) push_frame("R8", 8'h02, 5, a, wd);
        else push_frame("R8", (op == 3'd3) ? 8'h20 : 8'hD8, 4, a, 8'h00);
        for (int k = 0; k <= busy; k++) push_frame("R9", 8'h05, 2, 24'h0, 8'h00);
        exp_rsp.push_back({1'b1, 8'h02});
        exp_rsp_tag.push_back("R9");
      end
    endcase
    @(negedge clk);
    req_op = op; req_addr = a; req_len = 8'(n - 1); req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_frame.size() != 0 || exp_rsp.size() != 0 || !req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1", "cs_n", 64'(cs_n), 64'd1);
    chk(sclk == 1'b0, "R1", "sclk", 64'(sclk), 64'd0);
    chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    clk_div = 8'd1;
    run_req(3'd0, 24'h123456, 4, 8'h00, 0);
    run_req(3'd1, 24'hFFFFFE, 3, 8'h00, 0);
    run_req(3'd5, 24'h000000, 3, 8'h00, 0);
    run_req(3'd2, 24'h00ABCD, 1, 8'hA5, 0);
    run_req(3'd3, 24'h012000, 1, 8'h00, 2);
    run_req(3'd4, 24'h3F0000, 1, 8'h00, 1);
    clk_div = 8'd0;
    run_req(3'd0, 24'h000FFF, 1, 8'h00, 0);
    run_req(3'd1, 24'h800001, 2, 8'h00, 0);
    clk_div = 8'd3;
    run_req(3'd2, 24'h7F00C3, 1, 8'h5A, 3);
    run_req(3'd0, 24'hABCDEF, 2, 8'h00, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule